// File: doc/BRIEF.md
# Banked CPU Address Decoder

This block sits between a 16-bit CPU bus and the memories and register files behind it. Each cycle it looks at the address and raises one target select line. It also produces the local offset within that target, a store strobe for the target or a control strobe for the cartridge bank controller, and the read data the CPU should see.

Unmapped, blocked or unselected reads return 0xFF. The block holds the bank number for the upper working-RAM window. That register is written and read through one I/O address.

External RAM is shared by three sources. A clock register, the bank controller's own read data and the RAM itself reach that space in a fixed order, and reads and writes resolve that order differently. Attribute memory answers only while the video engine is in a mode that leaves it free.

Top module: `banked_addr_decoder`

## Requirements
- R1: `sel` is one-hot or all zero. Its bit positions are: 0 fixed ROM (0x0000-0x3FFF), 1 banked ROM (0x4000-0x7FFF), 2 video RAM (0x8000-0x9FFF), 3 external RAM, 4 clock register, 5 working-RAM low window (0xC000-0xCFFF), 6 working-RAM banked window (0xD000-0xDFFF), 7 attribute memory, 8 I/O, 9 high RAM, 10 interrupt enable.
- R2: 0xE000-0xEFFF selects the low working-RAM window. 0xF000-0xFDFF selects the banked window.
- R3: A write to address 0xFF70 loads the bank from `wdata[2:0]`, and a value of 0 loads bank 1. The new bank shows on `wram_bank` after the next rising edge. Reset leaves bank 1.
- R4: A read of 0xFF70 returns `{5'b11111, bank}` with no select. That address is never forwarded to I/O.
- R5: Attribute memory (0xFE00-0xFE9F, offset `addr[7:0]`) is selected only when `video_mode` is 0 or 1. Otherwise reads give 0xFF and writes raise no strobe.
- R6: The hole 0xFEA0-0xFEFF selects nothing, reads 0xFF and raises no strobe.
- R7: 0xFF00-0xFF7F is I/O, 0xFF80-0xFFFE is high RAM, and 0xFFFF is interrupt enable.
- R8: External RAM (0xA000-0xBFFF) reads are resolved in this order: the clock register if `clk_reg_en` is set, then the controller's data if `ctrl_rd_valid` is set, then RAM if `xram_en` and `xram_present` are both set. If none applies, the read returns 0xFF.
- R9: External RAM writes go to the clock register if it is enabled. Otherwise they go to RAM if it is enabled and present. Otherwise they raise `ctrl_we` and not `tgt_we`.
- R10: Any write below 0x8000 raises `ctrl_we` and never `tgt_we`.
- R11: `local_ofs` is the address masked to the target size: 14 bits for ROM, 13 for video and external RAM, 12 for working RAM, 8 for attribute memory, 7 for I/O and high RAM, and 0 for interrupt enable.
- R12: For a selected target the read data is `tgt_rdata`. With `rd` low the read data is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 16 | CPU address |
| rd | input | 1 | Read cycle |
| wr | input | 1 | Write cycle |
| wdata | input | 8 | Write data (bank register) |
| video_mode | input | 2 | Current video engine mode |
| clk_reg_en | input | 1 | Clock register mapped into external RAM |
| ctrl_rd_valid | input | 1 | Bank controller supplies read data |
| ctrl_rdata | input | 8 | Bank controller read data |
| clk_rdata | input | 8 | Clock register read data |
| xram_en | input | 1 | External RAM access enabled |
| xram_present | input | 1 | External RAM fitted |
| tgt_rdata | input | 8 | Read data of the selected target |
| sel | output | 11 | Target select lines |
| local_ofs | output | 14 | Offset inside the target |
| tgt_we | output | 1 | Store strobe to the selected target |
| ctrl_we | output | 1 | Control write to the bank controller |
| rdata | output | 8 | Read data to the CPU |
| wram_bank | output | 3 | Active upper working-RAM bank |

## Verification
Every select, offset, strobe and read-data value is combinational from the inputs in the same cycle. The bench therefore drives each stimulus just after a falling edge and samples one nanosecond later, before the next rising edge.

The bank register is the only stored result. A bank write is driven in one low phase and captured at the following rising edge. The bench checks `wram_bank` and the 0xFF70 readback in the next low phase, one edge after the write.

// File: rtl/banked_addr_decoder.sv
module banked_addr_decoder #(
  parameter int DATA_W = 8,
  parameter int BANK_W = 3,
  parameter logic [15:0] BANK_REG_ADDR = 16'hFF70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        video_mode,
  input  logic              clk_reg_en,
  input  logic              ctrl_rd_valid,
  input  logic [DATA_W-1:0] ctrl_rdata,
  input  logic [DATA_W-1:0] clk_rdata,
  input  logic              xram_en,
  input  logic              xram_present,
  input  logic [DATA_W-1:0] tgt_rdata,
  output logic [10:0]       sel,
  output logic [13:0]       local_ofs,
  output logic              tgt_we,
  output logic              ctrl_we,
  output logic [DATA_W-1:0] rdata,
  output logic [BANK_W-1:0] wram_bank
);
  localparam int S_ROM0 = 0, S_ROMX = 1, S_VRAM = 2, S_XRAM = 3, S_CLK = 4,
                 S_WLO = 5, S_WHI = 6, S_OAM = 7, S_IO = 8, S_HRAM = 9, S_IE = 10;
  localparam logic [DATA_W-1:0] OPEN_BUS = '1;
  localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);

  logic [DATA_W-1:0] rd_val;
  logic              bank_hit, oam_free, ram_ok;
  logic              unused_wdata;

  assign bank_hit = (addr == BANK_REG_ADDR);
  assign oam_free = ~video_mode[1];
  assign ram_ok   = xram_en & xram_present;
  assign unused_wdata = ^wdata[DATA_W-1:BANK_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wram_bank <= BANK_ONE;
    else if (wr && bank_hit)
      wram_bank <= (wdata[BANK_W-1:0] == '0) ? BANK_ONE : wdata[BANK_W-1:0];
  end

  always_comb begin
    sel       = '0;
    local_ofs = '0;
    tgt_we    = 1'b0;
    ctrl_we   = 1'b0;
    rd_val    = OPEN_BUS;
    unique case (addr[15:12])
      4'h0, 4'h1, 4'h2, 4'h3: begin
        sel[S_ROM0] = 1'b1;
        local_ofs   = addr[13:0];
        rd_val      = tgt_rdata;
        ctrl_we     = wr;
      end
      4'h4, 4'h5, 4'h6, 4'h7: begin
        sel[S_ROMX] = 1'b1;
        local_ofs   = addr[13:0];
        rd_val      = tgt_rdata;
        ctrl_we     = wr;
      end
      4'h8, 4'h9: begin
        sel[S_VRAM] = 1'b1;
        local_ofs   = {1'b0, addr[12:0]};
        rd_val      = tgt_rdata;
        tgt_we      = wr;
      end
      4'hA, 4'hB: begin
        local_ofs = {1'b0, addr[12:0]};
        if (clk_reg_en) begin
          sel[S_CLK] = 1'b1;
          rd_val     = clk_rdata;
          tgt_we     = wr;
        end else begin
          sel[S_XRAM] = ram_ok & ~(rd & ctrl_rd_valid);
          if (ctrl_rd_valid)  rd_val = ctrl_rdata;
          else if (ram_ok)    rd_val = tgt_rdata;
          tgt_we  = wr & ram_ok;
          ctrl_we = wr & ~ram_ok;
        end
      end
      4'hC, 4'hE: begin
        sel[S_WLO] = 1'b1;
        local_ofs  = {2'b0, addr[11:0]};
        rd_val     = tgt_rdata;
        tgt_we     = wr;
      end
      4'hD: begin
        sel[S_WHI] = 1'b1;
        local_ofs  = {2'b0, addr[11:0]};
        rd_val     = tgt_rdata;
        tgt_we     = wr;
      end
      default: begin
        if (addr < 16'hFE00) begin
          sel[S_WHI] = 1'b1;
          local_ofs  = {2'b0, addr[11:0]};
          rd_val     = tgt_rdata;
          tgt_we     = wr;
        end else if (addr < 16'hFEA0) begin
          if (oam_free) begin
            sel[S_OAM] = 1'b1;
            local_ofs  = {6'b0, addr[7:0]};
            rd_val     = tgt_rdata;
            tgt_we     = wr;
          end
        end else if (addr < 16'hFF00) begin
          rd_val = OPEN_BUS;
        end else if (bank_hit) begin
          rd_val = {{(DATA_W-BANK_W){1'b1}}, wram_bank};
        end else if (addr < 16'hFF80) begin
          sel[S_IO] = 1'b1;
          local_ofs = {7'b0, addr[6:0]};
          rd_val    = tgt_rdata;
          tgt_we    = wr;
        end else if (addr != 16'hFFFF) begin
          sel[S_HRAM] = 1'b1;
          local_ofs   = {7'b0, addr[6:0]};
          rd_val      = tgt_rdata;
          tgt_we      = wr;
        end else begin
          sel[S_IE] = 1'b1;
          rd_val    = tgt_rdata;
          tgt_we    = wr;
        end
      end
    endcase
  end

  assign rdata = rd ? rd_val : OPEN_BUS;

  a_r1_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel));
  a_r3_bank_nonzero: assert property (@(posedge clk) disable iff (!rst_n) wram_bank != '0);
  a_r3_zero_to_one: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bank_hit && wdata[BANK_W-1:0] == '0) |=> (wram_bank == BANK_ONE));
  a_r3_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && bank_hit) |=> $stable(wram_bank));
  a_r5_oam_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= 16'hFE00 && addr < 16'hFEA0 && video_mode[1]) |-> (sel == '0 && !tgt_we));
  a_r6_hole_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= 16'hFEA0 && addr < 16'hFF00) |-> (sel == '0 && !tgt_we && !ctrl_we));
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n) !(tgt_we && ctrl_we));
  a_r10_rom_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !addr[15]) |-> (ctrl_we && !tgt_we));
endmodule

// File: tb/banked_addr_decoder_tb.sv
module banked_addr_decoder_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic rd = 0, wr = 0;
  logic [7:0] wdata = '0;
  logic [1:0] video_mode = '0;
  logic clk_reg_en = 0, ctrl_rd_valid = 0, xram_en = 0, xram_present = 0;
  logic [7:0] ctrl_rdata = 8'h3C, clk_rdata = 8'hC3, tgt_rdata;
  logic [10:0] sel;
  logic [13:0] local_ofs;
  logic tgt_we, ctrl_we;
  logic [7:0] rdata;
  logic [2:0] wram_bank;
  int checks = 0, failures = 0;

  assign tgt_rdata = addr[7:0] ^ 8'h5A;
  always #2.5 clk = ~clk;

  banked_addr_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .video_mode(video_mode), .clk_reg_en(clk_reg_en), .ctrl_rd_valid(ctrl_rd_valid),
    .ctrl_rdata(ctrl_rdata), .clk_rdata(clk_rdata), .xram_en(xram_en),
    .xram_present(xram_present), .tgt_rdata(tgt_rdata), .sel(sel),
    .local_ofs(local_ofs), .tgt_we(tgt_we), .ctrl_we(ctrl_we), .rdata(rdata),
    .wram_bank(wram_bank));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic probe(logic [15:0] a, logic r, logic w, logic [7:0] d);
    @(negedge clk);
    addr = a; rd = r; wr = w; wdata = d;
    #1;
  endtask

  task automatic t_reset;
    probe(16'hC000, 0, 0, 0);
    check("R3 reset bank", wram_bank, 1);
    check("R12 rd low", rdata, 8'hFF);
  endtask

  task automatic t_regions;
    logic [15:0] al [14] = '{16'h1234, 16'h5ABC, 16'h9FFF, 16'hC123, 16'hE456, 16'hD789,
                             16'hF100, 16'hFDFF, 16'hFF10, 16'hFF80, 16'hFFFE, 16'hFFFF,
                             16'h0000, 16'h7FFF};
    logic [10:0] sl [14] = '{11'h001, 11'h002, 11'h004, 11'h020, 11'h020, 11'h040,
                             11'h040, 11'h040, 11'h100, 11'h200, 11'h200, 11'h400,
                             11'h001, 11'h002};
    logic [13:0] ol [14] = '{14'h1234, 14'h1ABC, 14'h1FFF, 14'h123, 14'h456, 14'h789,
                             14'h100, 14'hDFF, 14'h10, 14'h0, 14'h7E, 14'h0,
                             14'h0, 14'h3FFF};
    for (int i = 0; i < 14; i++) begin
      probe(al[i], 1, 0, 0);
      check("R1 R2 R7 sel", sel, sl[i]);
      check("R11 offset", local_ofs, ol[i]);
      check("R12 rdata", rdata, al[i][7:0] ^ 8'h5A);
    end
  endtask

  task automatic t_bank;
    probe(16'hFF70, 0, 1, 8'hFD);
    probe(16'hFF70, 1, 0, 0);
    check("R3 bank from low bits", wram_bank, 5);
    check("R4 readback", rdata, 8'hFD);
    check("R4 no io select", sel, 0);
    probe(16'hFF70, 0, 1, 8'h00);
    probe(16'hD000, 1, 0, 0);
    check("R3 zero maps to one", wram_bank, 1);
    probe(16'hFF70, 0, 1, 8'h0A);
    probe(16'hFF70, 1, 0, 0);
    check("R3 bank 2", wram_bank, 2);
    check("R4 readback 2", rdata, 8'hFA);
  endtask

  task automatic t_oam;
    video_mode = 2'd1;
    probe(16'hFE10, 1, 0, 0);
    check("R5 oam sel", sel, 11'h080);
    check("R5 oam ofs", local_ofs, 14'h10);
    check("R5 oam data", rdata, 8'h4A);
    probe(16'hFE9F, 0, 1, 0);
    check("R5 oam write", tgt_we, 1);
    video_mode = 2'd2;
    probe(16'hFE10, 1, 0, 0);
    check("R5 blocked read", rdata, 8'hFF);
    check("R5 blocked sel", sel, 0);
    video_mode = 2'd3;
    probe(16'hFE10, 0, 1, 0);
    check("R5 blocked write", tgt_we, 0);
    video_mode = 2'd0;
  endtask

  task automatic t_hole;
    probe(16'hFEA0, 1, 0, 0);
    check("R6 hole read", rdata, 8'hFF);
    check("R6 hole sel", sel, 0);
    probe(16'hFEFF, 0, 1, 0);
    check("R6 hole strobes", {tgt_we, ctrl_we}, 0);
  endtask

  task automatic t_xram_rd;
    clk_reg_en = 1; ctrl_rd_valid = 1; xram_en = 1; xram_present = 1;
    probe(16'hA005, 1, 0, 0);
    check("R8 clock first", rdata, 8'hC3);
    check("R8 clock sel", sel, 11'h010);
    clk_reg_en = 0;
    probe(16'hA005, 1, 0, 0);
    check("R8 controller second", rdata, 8'h3C);
    check("R8 controller no sel", sel, 0);
    ctrl_rd_valid = 0;
    probe(16'hBFFF, 1, 0, 0);
    check("R8 ram third", rdata, 8'hA5);
    check("R8 ram sel", sel, 11'h008);
    check("R11 xram ofs", local_ofs, 14'h1FFF);
    xram_present = 0;
    probe(16'hA005, 1, 0, 0);
    check("R8 open", rdata, 8'hFF);
    xram_en = 0;
  endtask

  task automatic t_xram_wr;
    clk_reg_en = 1;
    probe(16'hA000, 0, 1, 0);
    check("R9 clock write", {tgt_we, ctrl_we, sel}, {2'b10, 11'h010});
    clk_reg_en = 0; xram_en = 1; xram_present = 1; ctrl_rd_valid = 1;
    probe(16'hA000, 0, 1, 0);
    check("R9 ram write", {tgt_we, ctrl_we, sel}, {2'b10, 11'h008});
    xram_en = 0;
    probe(16'hA000, 0, 1, 0);
    check("R9 controller write", {tgt_we, ctrl_we}, 2'b01);
    ctrl_rd_valid = 0; xram_present = 0;
  endtask

  task automatic t_rom_wr;
    probe(16'h2000, 0, 1, 8'h11);
    check("R10 rom0 write", {tgt_we, ctrl_we}, 2'b01);
    probe(16'h7FFF, 0, 1, 8'h11);
    check("R10 romx write", {tgt_we, ctrl_we}, 2'b01);
    probe(16'hC000, 0, 1, 0);
    check("R10 ram write", {tgt_we, ctrl_we}, 2'b10);
    probe(16'hC000, 0, 0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        t_reset();
        t_regions();
        t_bank();
        t_oam();
        t_hole();
        t_xram_rd();
        t_xram_wr();
        t_rom_wr();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule